// File: doc/BRIEF.md
# Line Receiver Output Formatter

This block sits behind an alternate-mark-inversion line receiver. For every bit period the receiver reports a positive-pulse flag, a negative-pulse flag and a recovered bit clock. The formatter puts these on a two-rail output whose meaning is selectable. In bipolar mode the rails repeat the two pulse indications. In binary mode one rail carries decoded data and the other raises a line-code-violation flag. A control input picks which edge of the output clock updates the rails. An active-low drive input turns off the output drivers while decoding carries on inside, so several receivers can share a wired-OR bus. When the receiver reports loss of signal, the output clock comes from a local reference clock in place of the recovered clock.

All inputs are synchronous to a fast system clock `clk`, and the line and reference clocks arrive as sampled levels. A bit is taken on each rising edge of the line clock. The output clock is a registered copy of the selected source. The rails change one system cycle after the selected edge of that registered clock.

A polarity tracker inside the decoder has three named states. LAST_NONE is the state after reset and after a double-rail bit. LAST_POS follows a positive pulse and LAST_NEG follows a negative pulse. Named transitions: POS_TAKEN (any state to LAST_POS on a positive-only bit), NEG_TAKEN (any state to LAST_NEG on a negative-only bit), BOTH_CLEAR (any state to LAST_NONE when both rails are high), and IDLE_HOLD (no pulse, state kept).

Top module: `rx_out_fmt`

## Requirements
- R1: With `binary_sel_i`=0, after each selected output-clock edge `rail_p_o` equals the positive-pulse flag and `rail_n_o` equals the negative-pulse flag of the most recently taken bit.
- R2: With `binary_sel_i`=1, after each selected edge `rail_p_o` is 1 when the latest bit had a positive or a negative pulse, and 0 when it had neither.
- R3: With `edge_rise_i`=0 the rails update one `clk` cycle after a falling edge of `out_clk_o`; with `edge_rise_i`=1 they update one cycle after a rising edge; at all other times they hold.
- R4: With `drive_n_i`=0, both `clk_oe_o` and `data_oe_o` are 0; with `drive_n_i`=1 both are 1.
- R5: While `drive_n_i`=0, bit decoding and polarity tracking continue, so the violation flag that follows re-enabling reflects bits taken while disabled.
- R6: With `sig_lost_n_i`=0, `out_clk_o` follows `ref_clk_i` one cycle later; with it at 1, `out_clk_o` follows `line_clk_i` one cycle later.
- R7: In binary mode `rail_n_o` reports a violation (1) for a single-rail bit whose polarity matches the previous pulse-carrying bit.
- R8: In binary mode a bit with both rails high reports a violation, and the polarity memory then returns to LAST_NONE, so the next single-rail pulse is not a violation.
- R9: Synchronous reset `rst` puts the tracker in LAST_NONE and drives `rail_p_o` and `rail_n_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| line_clk_i | input | 1 | Recovered line clock level |
| ref_clk_i | input | 1 | Local reference clock level |
| sig_lost_n_i | input | 1 | Loss of signal, active low |
| pulse_p_i | input | 1 | Positive pulse seen in this bit |
| pulse_n_i | input | 1 | Negative pulse seen in this bit |
| binary_sel_i | input | 1 | 0 = bipolar rails, 1 = data plus violation |
| edge_rise_i | input | 1 | 0 = update on falling edge, 1 = on rising edge |
| drive_n_i | input | 1 | Output drive enable, active low disables |
| out_clk_o | output | 1 | Output clock |
| clk_oe_o | output | 1 | Drive enable for the clock output |
| rail_p_o | output | 1 | Positive rail or decoded data |
| rail_n_o | output | 1 | Negative rail or violation flag |
| data_oe_o | output | 1 | Drive enable for both rails |

## Verification
Assertions check on every cycle that the rails stay still outside selected edges, that each update copies the decoder result in the form the mode asks for, that matching-polarity bits raise a violation, that the clock source follows loss of signal, and that reset clears the state. Only the bench's scenarios show end-to-end bit sequences. These include alternating and repeated polarities, double-rail bits, a violation that spans a disabled interval, and the shift in update timing when the edge selection changes.

// File: rtl/rx_out_fmt_pkg.sv
package rx_out_fmt_pkg;
    typedef enum logic [1:0] {
        LAST_NONE = 2'd0,
        LAST_POS  = 2'd1,
        LAST_NEG  = 2'd2
    } pol_state_t;

    typedef struct packed {
        logic pos;
        logic neg;
        logic data;
        logic viol;
    } bit_result_t;
endpackage

// File: rtl/rx_edge_det.sv
module rx_edge_det #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign rise_o[i] = level_i[i] & ~prev_q[i];
        assign fall_o[i] = ~level_i[i] & prev_q[i];
    end
endmodule

// File: rtl/rx_pol_decoder.sv
module rx_pol_decoder
    import rx_out_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe_i,
    input  logic        pos_i,
    input  logic        neg_i,
    output bit_result_t res_o
);
    pol_state_t state_q, state_d;
    bit_result_t res_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LAST_NONE;
        else     state_q <= state_d;
    end

    // Next state: POS_TAKEN, NEG_TAKEN, BOTH_CLEAR, IDLE_HOLD
    always_comb begin
        state_d = state_q;
        if (strobe_i) begin
            unique case ({pos_i, neg_i})
                2'b10:   state_d = LAST_POS;
                2'b01:   state_d = LAST_NEG;
                2'b11:   state_d = LAST_NONE;
                default: state_d = state_q;
            endcase
        end
    end

    // Result for the bit being taken
    always_comb begin
        res_d.pos  = pos_i;
        res_d.neg  = neg_i;
        res_d.data = pos_i | neg_i;
        res_d.viol = 1'b0;
        unique case (state_q)
            LAST_POS:  res_d.viol = pos_i;
            LAST_NEG:  res_d.viol = neg_i;
            default:   res_d.viol = 1'b0;
        endcase
        if (pos_i && neg_i) res_d.viol = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)           res_o <= '0;
        else if (strobe_i) res_o <= res_d;
    end

    // R7: repeat of a positive pulse is flagged
    a_r7_same_pol_flag: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && pos_i && !neg_i && state_q == LAST_POS) |=> res_o.viol);

    // R8: double rail flags and clears the memory
    a_r8_both_clear: assert property (@(posedge clk) disable iff (rst)
        (strobe_i && pos_i && neg_i) |=> (res_o.viol && state_q == LAST_NONE));

    // R9: reset returns tracker to LAST_NONE
    a_r9_reset_state: assert property (@(posedge clk)
        rst |=> state_q == LAST_NONE);
endmodule

// File: rtl/rx_rail_fmt.sv
module rx_rail_fmt
    import rx_out_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        upd_i,
    input  logic        binary_i,
    input  bit_result_t res_i,
    output logic        rail_p_o,
    output logic        rail_n_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rail_p_o <= 1'b0;
            rail_n_o <= 1'b0;
        end else if (upd_i) begin
            rail_p_o <= binary_i ? res_i.data : res_i.pos;
            rail_n_o <= binary_i ? res_i.viol : res_i.neg;
        end
    end

    // R1: bipolar pass-through
    a_r1_bipolar: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !binary_i) |=> (rail_p_o == $past(res_i.pos) && rail_n_o == $past(res_i.neg)));

    // R2: binary data carries any pulse
    a_r2_binary: assert property (@(posedge clk) disable iff (rst)
        (upd_i && binary_i) |=> (rail_p_o == $past(res_i.pos | res_i.neg)));

    // R3: hold between update edges
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> ($stable(rail_p_o) && $stable(rail_n_o)));

    // R9: reset clears rails
    a_r9_reset_rails: assert property (@(posedge clk)
        rst |=> (!rail_p_o && !rail_n_o));
endmodule

// File: rtl/rx_out_fmt.sv
module rx_out_fmt
    import rx_out_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic line_clk_i,
    input  logic ref_clk_i,
    input  logic sig_lost_n_i,
    input  logic pulse_p_i,
    input  logic pulse_n_i,
    input  logic binary_sel_i,
    input  logic edge_rise_i,
    input  logic drive_n_i,
    output logic out_clk_o,
    output logic clk_oe_o,
    output logic rail_p_o,
    output logic rail_n_o,
    output logic data_oe_o
);
    localparam int NCLK = 2;  // [0] line clock, [1] output clock

    logic        out_clk_q;
    logic [NCLK-1:0] rise, fall;
    bit_result_t res;
    logic        upd;

    // Clock source selection on loss of signal
    always_ff @(posedge clk) begin
        if (rst) out_clk_q <= 1'b0;
        else     out_clk_q <= sig_lost_n_i ? line_clk_i : ref_clk_i;
    end
    assign out_clk_o = out_clk_q;

    rx_edge_det #(.WIDTH(NCLK)) u_edges (
        .clk     (clk),
        .rst     (rst),
        .level_i ({out_clk_q, line_clk_i}),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    rx_pol_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (rise[0]),
        .pos_i    (pulse_p_i),
        .neg_i    (pulse_n_i),
        .res_o    (res)
    );

    assign upd = edge_rise_i ? rise[1] : fall[1];

    rx_rail_fmt u_fmt (
        .clk      (clk),
        .rst      (rst),
        .upd_i    (upd),
        .binary_i (binary_sel_i),
        .res_i    (res),
        .rail_p_o (rail_p_o),
        .rail_n_o (rail_n_o)
    );

    assign clk_oe_o  = drive_n_i;
    assign data_oe_o = drive_n_i;

    // R6: clock source follows loss of signal
    a_r6_ref_clk: assert property (@(posedge clk) disable iff (rst)
        !sig_lost_n_i |=> out_clk_o == $past(ref_clk_i));
    a_r6_line_clk: assert property (@(posedge clk) disable iff (rst)
        sig_lost_n_i |=> out_clk_o == $past(line_clk_i));
endmodule

// File: tb/tb_rx_out_fmt.sv
module tb_rx_out_fmt;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic clk = 0, rst = 1;
    logic line_clk = 0, ref_clk = 0, lost_n = 1;
    logic pp = 0, pn = 0, bsel = 0, erise = 0, drv_n = 1;
    logic oclk, coe, rp, rn, doe;

    int checks = 0, fails = 0;
    logic [1:0] exp_q[$];
    logic [1:0] last_pol = 2'd0; // 0 none, 1 pos, 2 neg
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_out_fmt dut (
        .clk(clk), .rst(rst), .line_clk_i(line_clk), .ref_clk_i(ref_clk),
        .sig_lost_n_i(lost_n), .pulse_p_i(pp), .pulse_n_i(pn),
        .binary_sel_i(bsel), .edge_rise_i(erise), .drive_n_i(drv_n),
        .out_clk_o(oclk), .clk_oe_o(coe), .rail_p_o(rp), .rail_n_o(rn),
        .data_oe_o(doe)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: one bit period, expected result pushed to scoreboard
    task automatic send_bit(input logic p, input logic n);
        logic cv;
        @(negedge clk);
        pp = p; pn = n;
        cv = (p && n) || (p && !n && last_pol == 2'd1) || (n && !p && last_pol == 2'd2);
        if (bsel) exp_q.push_back({p | n, cv});
        else      exp_q.push_back({p, n});
        if (p && n)  last_pol = 2'd0;
        else if (p)  last_pol = 2'd1;
        else if (n)  last_pol = 2'd2;
        line_clk = 1;
        repeat (HALF_BIT) @(negedge clk);
        line_clk = 0;
        repeat (HALF_BIT - 1) @(negedge clk);
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    // Monitor: compare after each selected output-clock edge (R1 R2 R3 R7 R8 R5)
    initial begin
        logic prev = 0;
        logic [1:0] e;
        forever begin
            @(negedge clk);
            if (((erise && oclk && !prev) || (!erise && !oclk && prev)) && exp_q.size() > 0) begin
                prev = oclk;
                @(negedge clk);
                e = exp_q.pop_front();
                check(bsel ? "R2/R7/R8/R3 binary" : "R1/R3 bipolar", {rp, rn}, e);
            end
            prev = oclk;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset rails", {rp, rn}, 2'b00);
        rst = 0;
        @(negedge clk);
        check("R9 after reset", {rp, rn}, 2'b00);
        check("R4 enabled", {coe, doe}, 2'b11);

        // R1 bipolar, falling-edge update
        bsel = 0; erise = 0;
        send_bit(1, 0); send_bit(0, 1); send_bit(0, 0); send_bit(1, 0); send_bit(1, 0);
        settle();

        // R3 rising-edge update, bipolar
        erise = 1;
        send_bit(0, 1); send_bit(1, 0); send_bit(0, 0); send_bit(0, 1);
        settle();
        // R3: rails hold between edges (last bit was neg only)
        check("R3 hold", {rp, rn}, 2'b01);

        // R2 R7 R8 binary mode
        bsel = 1; erise = 0;
        send_bit(0, 1);   // R7 repeat negative
        send_bit(1, 0);
        send_bit(1, 0);   // R7 repeat positive
        send_bit(0, 0);   // R2 zero
        send_bit(1, 1);   // R8 double rail
        send_bit(1, 0);   // R8 no violation after clear
        send_bit(0, 1);
        settle();

        // R4 R5 disabled, decoding continues
        drv_n = 0;
        @(negedge clk);
        check("R4 disabled oe", {coe, doe}, 2'b00);
        send_bit(0, 1);
        send_bit(0, 0);
        settle();
        drv_n = 1;
        @(negedge clk);
        check("R4 re-enabled oe", {coe, doe}, 2'b11);
        send_bit(0, 1);   // R5 violation against bit taken while disabled
        settle();

        // R6 clock source on loss of signal
        ref_clk = 1; line_clk = 0; lost_n = 0;
        repeat (2) @(negedge clk);
        check("R6 ref clock", {1'b0, oclk}, 2'b01);
        ref_clk = 0;
        repeat (2) @(negedge clk);
        check("R6 ref clock low", {1'b0, oclk}, 2'b00);
        ref_clk = 1; lost_n = 1;
        repeat (2) @(negedge clk);
        check("R6 line clock", {1'b0, oclk}, 2'b00);
        ref_clk = 0;
        settle();

        // R9 mid-run reset
        bsel = 0; erise = 1;
        send_bit(1, 1);
        settle();
        rst = 1;
        repeat (2) @(negedge clk);
        check("R9 reset clears rails", {rp, rn}, 2'b00);
        rst = 0; last_pol = 2'd0;
        bsel = 1; erise = 0;
        send_bit(1, 0);   // R9 memory cleared: no violation
        settle();

        if (exp_q.size() != 0) check("scoreboard drained", 2'(exp_q.size()), 2'd0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule